// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

This block is an 8-bit up-counter that advances on ticks from a programmable power-of-two prescaler. It runs in one of two modes. In interval mode each counter wrap raises a sticky overflow flag, and that flag drives a level interrupt. In watchdog mode a wrap drives a watchdog overflow output for a fixed window. If a configuration input allows it, the wrap also asks the system for an internal reset over the same window.

Software reaches the block through a two-address register port with combinational read data. Address 0 is the counter and address 1 is the control/status register. The overflow flag uses a read-then-write-zero clearing handshake, so a write that has not first seen the flag set cannot clear it by accident.

Top module: `wdit_top`

## Requirements
- R1: After reset the status register reads 0x18, the counter reads 0x00, and `irq_o`, `wdog_ovf_o` and `rst_req_o` are all low.
- R2: The status register layout is: bit 7 overflow flag, bit 6 mode (0 interval, 1 watchdog), bit 5 enable, bits 4:3 always read 1 and ignore writes, bits 2:0 clock select. Address 0 selects the counter and address 1 selects the status register.
- R3: Clock select codes 0..7 give divisors 2, 64, 128, 512, 2048, 8192, 32768 and 131072. When enable goes 1 from 0, the counter reads floor(n/divisor) mod 256 after n clock edges.
- R4: While enable is 0, the counter is held at 0, counter writes have no effect, and the prescaler restarts from zero.
- R5: While enabled, a counter write loads the written value at that edge. The write takes precedence over a tick in the same cycle, and counting continues from the loaded value.
- R6: In interval mode, a wrap from 0xFF to 0x00 sets the overflow flag at the same clock edge.
- R7: Writing 1 to bit 7 leaves the flag unchanged. Writing 0 to bit 7 clears the flag only if a status-register read strobe saw the flag at 1 after the previous status-register write.
- R8: `irq_o` is high exactly when the flag is 1, the mode is interval and `irq_en_i` is 1.
- R9: In watchdog mode a wrap does not set the flag. `wdog_ovf_o` goes high at the wrap edge and stays high for 8 cycles.
- R10: `rst_req_o` is high during the same 8 cycles as `wdog_ovf_o` if `rst_gen_en_i` was 1 at the wrap. Otherwise it stays low.
- R11: A watchdog wrap with `rst_gen_en_i` at 1 clears the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_addr | input | 1 | 0 counter, 1 status register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq_en_i | input | 1 | Interval interrupt enable |
| rst_gen_en_i | input | 1 | Watchdog wrap also requests internal reset |
| irq_o | output | 1 | Level interval interrupt |
| wdog_ovf_o | output | 1 | Watchdog overflow window |
| rst_req_o | output | 1 | Internal reset request window |

## Verification
The hardest state to reach is a set overflow flag that meets a reset-generating watchdog wrap. The flag can only be set in interval mode, so the stimulus first lets an interval wrap set it. It then rewrites the status register to select watchdog mode, using a write of 1 to bit 7 so the flag is kept. It then waits for the next wrap with reset generation enabled and checks that the flag has been cleared. The clearing handshake is covered in both orders: a write of 0 that no read preceded, which must leave the flag set, and a read strobe followed by a write of 0, which must clear it.

// File: rtl/wdit_pkg.sv
package wdit_pkg;
  localparam int CNT_W     = 8;
  localparam int CKS_W     = 3;
  localparam int PRE_W     = 17;
  localparam int PULSE_LEN = 8;

  typedef struct packed {
    logic             flag;
    logic             mode;
    logic             en;
    logic [1:0]       ones;
    logic [CKS_W-1:0] cks;
  } ctl_t;

  // number of prescaler bits that must be all ones for a tick
  function automatic logic [4:0] tick_bits(input logic [CKS_W-1:0] code);
    logic [4:0] b;
    case (code)
      3'd0:    b = 5'd1;
      3'd1:    b = 5'd6;
      3'd2:    b = 5'd7;
      3'd3:    b = 5'd9;
      3'd4:    b = 5'd11;
      3'd5:    b = 5'd13;
      3'd6:    b = 5'd15;
      default: b = 5'd17;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/wdit_prescaler.sv
module wdit_prescaler
  import wdit_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CKS_W-1:0] cks_i,
  output logic             tick_o
);
  logic [PW-1:0] pre_q, pre_d, mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PW; i++) begin
      if (i < int'(tick_bits(cks_i))) mask[i] = 1'b1;
    end
  end

  always_comb begin
    pre_d = run_i ? pre_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  assign tick_o = run_i && ((pre_q & mask) == mask);

  p_pre_restart_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !run_i |=> pre_q == '0);
endmodule

// File: rtl/wdit_counter.sv
module wdit_counter
  import wdit_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         ld, step;

  assign ld   = en_i && wr_i;
  assign step = en_i && tick_i && !wr_i;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)     cnt_d = '0;
    else if (ld)   cnt_d = wdata_i;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = step && (cnt_q == {W{1'b1}});

  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
  p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && tick_i && !wr_i) |=> cnt_q == W'($past(cnt_q) + 1'b1));
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && wr_i) |=> cnt_q == $past(wdata_i));
endmodule

// File: rtl/wdit_pulse.sv
module wdit_pulse
  import wdit_pkg::*;
#(
  parameter int LEN = PULSE_LEN
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rst_sel_i,
  output logic wdog_o,
  output logic rst_req_o
);
  localparam int LW = $clog2(LEN + 1);

  logic [LW-1:0] left_q, left_d;
  logic          sel_q, sel_d;

  always_comb begin
    left_d = left_q;
    sel_d  = sel_q;
    if (start_i) begin
      left_d = LW'(LEN);
      sel_d  = rst_sel_i;
    end else if (left_q != '0) begin
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      left_q <= left_d;
      sel_q  <= sel_d;
    end
  end

  assign wdog_o    = left_q != '0;
  assign rst_req_o = wdog_o && sel_q;

  p_req_inside_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_req_o |-> wdog_o);
  p_start_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    start_i |=> wdog_o);
endmodule

// File: rtl/wdit_ctl.sv
module wdit_ctl
  import wdit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [7:0]       wdata_i,
  input  logic             set_i,
  input  logic             wd_clr_i,
  output ctl_t             ctl_o
);
  logic             flag_q, flag_d, arm_q, arm_d;
  logic             mode_q, mode_d, en_q, en_d;
  logic [CKS_W-1:0] cks_q, cks_d;

  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    mode_d = mode_q;
    en_d   = en_q;
    cks_d  = cks_q;
    if (rd_i && flag_q) arm_d = 1'b1;
    if (wr_i) begin
      mode_d = wdata_i[6];
      en_d   = wdata_i[5];
      cks_d  = wdata_i[CKS_W-1:0];
      arm_d  = 1'b0;
      if (arm_q && !wdata_i[7]) flag_d = 1'b0;
    end
    if (wd_clr_i) flag_d = 1'b0;
    if (set_i)    flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
      mode_q <= 1'b0;
      en_q   <= 1'b0;
      cks_q  <= '0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
      mode_q <= mode_d;
      en_q   <= en_d;
      cks_q  <= cks_d;
    end
  end

  assign ctl_o = '{flag: flag_q, mode: mode_q, en: en_q, ones: 2'b11, cks: cks_q};

  p_flag_set_src_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(set_i));
  p_flag_clr_src_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(flag_q) |-> ($past(wr_i && arm_q && !wdata_i[7]) || $past(wd_clr_i)));
endmodule

// File: rtl/wdit_top.sv
module wdit_top
  import wdit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       irq_en_i,
  input  logic       rst_gen_en_i,
  output logic       irq_o,
  output logic       wdog_ovf_o,
  output logic       rst_req_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  ctl_t             ctl;
  logic             tick, wrap, set_flag, wd_start, wd_clr;
  logic [CNT_W-1:0] cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  wdit_ctl u_ctl (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .wr_i     (bus_wr && bus_addr),
    .rd_i     (bus_rd && bus_addr),
    .wdata_i  (bus_wdata),
    .set_i    (set_flag),
    .wd_clr_i (wd_clr),
    .ctl_o    (ctl)
  );

  wdit_prescaler u_pre (
    .clk    (clk),
    .rst_ni (rst_ni),
    .run_i  (ctl.en),
    .cks_i  (ctl.cks),
    .tick_o (tick)
  );

  wdit_counter u_cnt (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .en_i    (ctl.en),
    .tick_i  (tick),
    .wr_i    (bus_wr && !bus_addr),
    .wdata_i (bus_wdata),
    .cnt_o   (cnt),
    .wrap_o  (wrap)
  );

  assign set_flag = wrap && !ctl.mode;
  assign wd_start = wrap && ctl.mode;
  assign wd_clr   = wd_start && rst_gen_en_i;

  wdit_pulse u_pulse (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .start_i   (wd_start),
    .rst_sel_i (rst_gen_en_i),
    .wdog_o    (wdog_ovf_o),
    .rst_req_o (rst_req_o)
  );

  assign bus_rdata = bus_addr ? ctl : cnt;
  assign irq_o     = ctl.flag && !ctl.mode && irq_en_i;

  p_wd_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (wd_start && !rst_gen_en_i) |=> ctl.flag == $past(ctl.flag));
  p_wd_clears_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    wd_clr |=> !ctl.flag);
  p_ro_bits_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_addr |-> bus_rdata[4:3] == 2'b11);
  p_irq_mode_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o |-> (ctl.flag && irq_en_i));
endmodule

// File: tb/wdit_top_tb.sv
module wdit_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       irq_en_i = 1'b1, rst_gen_en_i = 1'b0;
  logic       irq_o, wdog_ovf_o, rst_req_o;
  int         checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  wdit_top u_dut (.*);

  typedef struct packed { logic [2:0] cks; int unsigned edges; logic [7:0] exp; } vec_t;
  localparam vec_t VECS [8] = '{
    '{3'd0, 20, 8'd10}, '{3'd1, 200, 8'd3}, '{3'd2, 300, 8'd2},
    '{3'd3, 1100, 8'd2}, '{3'd4, 4100, 8'd2}, '{3'd5, 8200, 8'd1},
    '{3'd6, 32768, 8'd1}, '{3'd7, 131072, 8'd1}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic peek(input logic a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    peek(1'b1, d); check("R1 ctl", d, 8'h18);
    peek(1'b0, d); check("R1 cnt", d, 8'h00);
    check("R1 outs", {irq_o, wdog_ovf_o, rst_req_o}, 3'b000);

    // R2 layout, read-only bits 4:3
    bus_write(1'b1, 8'h07); peek(1'b1, d); check("R2 ro ones", d, 8'h1F);
    bus_write(1'b1, 8'h00); peek(1'b1, d); check("R2 zero write", d, 8'h18);

    // R4 disabled: counter write ignored
    bus_write(1'b0, 8'h55); peek(1'b0, d); check("R4 write ignored", d, 8'h00);
    repeat (10) @(negedge clk); peek(1'b0, d); check("R4 held", d, 8'h00);

    // R5 load while enabled (cks0, enable at E0, load at E2)
    bus_write(1'b1, 8'h20);
    bus_write(1'b0, 8'h80); peek(1'b0, d); check("R5 load", d, 8'h80);
    repeat (4) @(negedge clk); peek(1'b0, d); check("R5 continue", d, 8'h82);
    bus_write(1'b1, 8'h00);

    // R3 prescaler table
    foreach (VECS[i]) begin
      bus_write(1'b1, {5'b00100, VECS[i].cks});
      repeat (VECS[i].edges) @(negedge clk);
      peek(1'b0, d); check($sformatf("R3 cks%0d", VECS[i].cks), d, VECS[i].exp);
      bus_write(1'b1, 8'h00);
    end

    // R6 interval wrap at edge 512 for divisor 2
    bus_write(1'b1, 8'h20);
    repeat (511) @(negedge clk);
    peek(1'b1, d); check("R6 before wrap", d[7], 1'b0);
    @(negedge clk);
    peek(1'b1, d); check("R6 flag set", d[7], 1'b1);
    peek(1'b0, d); check("R6 cnt wrapped", d, 8'h00);
    check("R8 irq on", irq_o, 1'b1);

    // R7 clear handshake
    bus_write(1'b1, 8'h20); peek(1'b1, d); check("R7 no read, no clear", d[7], 1'b1);
    bus_write(1'b1, 8'hA0); peek(1'b1, d); check("R7 write one", d[7], 1'b1);
    bus_read(1'b1);
    bus_write(1'b1, 8'h20); peek(1'b1, d); check("R7 cleared", d[7], 1'b0);
    check("R8 irq off", irq_o, 1'b0);

    // R8 gating by enable input and mode
    n = 0;
    while (!irq_o && n < 700) begin @(negedge clk); n++; end
    check("R6 second wrap", irq_o, 1'b1);
    irq_en_i = 1'b0; #1; check("R8 irq_en low", irq_o, 1'b0);
    irq_en_i = 1'b1; #1; check("R8 irq_en high", irq_o, 1'b1);
    bus_write(1'b1, 8'hE0);
    peek(1'b1, d); check("R11 flag kept", d[7], 1'b1);
    check("R8 wd mode masks", irq_o, 1'b0);

    // R10/R11 watchdog wrap with reset request
    rst_gen_en_i = 1'b1;
    n = 0;
    while (!wdog_ovf_o && n < 700) begin @(negedge clk); n++; end
    check("R9 wdog rise", wdog_ovf_o, 1'b1);
    check("R10 req rise", rst_req_o, 1'b1);
    peek(1'b1, d); check("R11 flag cleared", d[7], 1'b0);
    n = 0;
    while (wdog_ovf_o && n < 20) begin
      if (!rst_req_o) check("R10 req with wdog", rst_req_o, 1'b1);
      @(negedge clk); n++;
    end
    check("R9 width", n, 8);

    // R9/R10 watchdog wrap without reset request, flag stays 0
    rst_gen_en_i = 1'b0;
    n = 0;
    while (!wdog_ovf_o && n < 700) begin @(negedge clk); n++; end
    check("R9 second rise", wdog_ovf_o, 1'b1);
    check("R10 no req", rst_req_o, 1'b0);
    peek(1'b1, d); check("R9 no flag", d[7], 1'b0);
    n = 0;
    while (wdog_ovf_o && n < 20) begin @(negedge clk); n++; end
    check("R9 width 2", n, 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule